// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash. It drives the flash address, write data, output enable for the data bus, write strobe and read strobe. It runs three jobs to completion without software help: reading the two identifier words, programming one word, and erasing one 4 KB sector. A request carries an operation code, a target word address, a write word and a verify length counted in words. The block finishes each job by raising a one-cycle done pulse, with a status code and the last identifier words held on its outputs.

Program and erase both start with the flash's unlock writes. The block then polls the target location. It treats the job as complete when the busy bit of two consecutive reads holds the same value, or it gives up after a parameterised number of toggling reads. After that it reads the result back and checks it. Each bus access takes a fixed, parameterised number of clocks. The write strobe is framed by one clock of address and data setup before it and one clock of hold after it.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every command starts with an unlock pair: data 0xAA written to word address 0x5555, then data 0x55 written to word address 0x2AAA.
- R2: Operation code 2 (program) issues exactly four writes: the unlock pair, 0xA0 to 0x5555, then the write word to the target address. The flash then holds that word and the status is 0 (ok).
- R3: Operation code 3 (erase) issues exactly six writes: the unlock pair, 0x80 to 0x5555, the unlock pair again, then 0x30 to the target address with its low log2(4096/bytes-per-word) bits cleared (the sector base).
- R4: Operation code 1 (identifier query) writes the unlock pair and 0x90 to 0x5555. It then reads word 0 onto id_mfr and word 1 onto id_dev. It then writes the unlock pair and 0xF0 to 0x5555, so the flash leaves identifier mode. That is 6 writes and 2 reads.
- R5: Polling reads the poll address: the target for a program, the sector base for an erase. Polling stops at the first read whose bit 6 equals bit 6 of the previous read.
- R6: If POLL_LIMIT reads in a row each differ in bit 6 from the read before, polling stops and the status becomes 1 (timeout). That is POLL_LIMIT+1 poll reads in all. The status output never takes the value 3.
- R7: After a program, one read of the target is compared with the write word. A mismatch gives status 2 (verify fail), unless the status is already 1, which then stays 1.
- R8: After an erase, the words from the sector base upward are read for req_len words, and each must be all ones. The first word that is not all ones ends the check with status 2, unless the status is already 1. A req_len of 0 skips the check.
- R9: The write strobe stays low for exactly ACC_CLKS clocks. Address and write data are stable on the clock the strobe falls, the clock it rises and the clock after. The write and read strobes are never low together.
- R10: done is a one-cycle pulse, and busy is low while done is high. A request made while busy is high is ignored, and so is a request with operation code 0.
- R11: After reset, busy, done, status, id_mfr and id_dev are 0, and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 2 | 0 none, 1 identifier query, 2 program, 3 sector erase |
| req_addr | input | AW | Target word address |
| req_wdata | input | DW | Word to program |
| req_len | input | LW | Words to blank-check after an erase |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 verify fail |
| id_mfr | output | DW | Manufacturer word from the last query |
| id_dev | output | DW | Device word from the last query |
| flash_addr | output | AW | Flash word address |
| flash_dq_out | output | DW | Write data to the flash |
| flash_dq_oe | output | 1 | Drive enable for flash_dq_out |
| flash_dq_in | input | DW | Read data from the flash |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_oe_n | output | 1 | Read strobe, active low |

## Verification
The bound checker watches the bus timing on every cycle: write strobe width, address and data stability around both strobe edges, and mutual exclusion of the two strobes. It also checks the shape of done against busy and that status stays inside its legal codes. The order of command words, the number of poll reads for a given busy length, the precedence of timeout over verify failure, the extent of the erase blank check and the dropping of requests while busy only show up in the bench. There, a behavioural flash model decodes the write cycles and counts every access.

// File: rtl/nor_seq_pkg.sv
// Package: shared encodings for the NOR command sequencer.
// Assumes word-addressed flash with command codes on the low data byte.
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ID    = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_TIMEOUT = 2'd1,
        ST_VFAIL   = 2'd2
    } status_e;

    typedef enum logic [2:0] {
        K_WR   = 3'd0,
        K_ID0  = 3'd1,
        K_ID1  = 3'd2,
        K_POLL = 3'd3,
        K_VFY  = 3'd4,
        K_END  = 3'd5
    } kind_e;

    localparam logic [15:0] ADDR_KEY_HI   = 16'h5555;
    localparam logic [15:0] ADDR_KEY_LO   = 16'h2AAA;
    localparam logic [7:0]  CMD_KEY1      = 8'hAA;
    localparam logic [7:0]  CMD_KEY2      = 8'h55;
    localparam logic [7:0]  CMD_PROG      = 8'hA0;
    localparam logic [7:0]  CMD_ERASE_ARM = 8'h80;
    localparam logic [7:0]  CMD_SECTOR    = 8'h30;
    localparam logic [7:0]  CMD_ID_ENTER  = 8'h90;
    localparam logic [7:0]  CMD_ID_LEAVE  = 8'hF0;
    localparam int          BUSY_BIT      = 6;

endpackage

// File: rtl/nor_bus_engine.sv
// Module: nor_bus_engine
// Runs one asynchronous flash access per start pulse. A write holds address
// and data one clock, pulls the write strobe low for ACC_CLKS clocks, then
// holds for one more clock. A read does the same with the read strobe and
// captures the data on the last strobe clock. ack pulses once per access.
// Assumes start is only raised while the engine is idle (ack seen).
module nor_bus_engine #(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter int ACC_CLKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dq_out,
    output logic          bus_dq_oe,
    output logic          bus_we_n,
    output logic          bus_oe_n,
    input  logic [DW-1:0] bus_dq_in
);

    localparam int CW = $clog2(ACC_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(ACC_CLKS - 1);

    typedef enum logic [1:0] {E_IDLE, E_SETUP, E_STROBE, E_HOLD} eng_e;

    eng_e          es;
    logic [CW-1:0] cnt;
    logic          wr_q;

    // Access state machine: setup, strobe window, hold, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            es         <= E_IDLE;
            cnt        <= '0;
            wr_q       <= 1'b0;
            ack        <= 1'b0;
            rdata      <= '0;
            bus_addr   <= '0;
            bus_dq_out <= '0;
            bus_dq_oe  <= 1'b0;
            bus_we_n   <= 1'b1;
            bus_oe_n   <= 1'b1;
        end else begin
            ack <= 1'b0;
            unique case (es)
                E_IDLE: begin
                    if (start) begin
                        bus_addr   <= addr_i;
                        bus_dq_out <= wr ? data_i : '0;
                        bus_dq_oe  <= wr;
                        wr_q       <= wr;
                        es         <= E_SETUP;
                    end
                end
                E_SETUP: begin
                    cnt <= '0;
                    if (wr_q) bus_we_n <= 1'b0;
                    else      bus_oe_n <= 1'b0;
                    es <= E_STROBE;
                end
                E_STROBE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        bus_we_n <= 1'b1;
                        bus_oe_n <= 1'b1;
                        if (!wr_q) rdata <= bus_dq_in;
                        es <= E_HOLD;
                    end
                end
                E_HOLD: begin
                    ack       <= 1'b1;
                    bus_dq_oe <= 1'b0;
                    es        <= E_IDLE;
                end
                default: es <= E_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nor_toggle_watch.sv
// Module: nor_toggle_watch
// Tracks the busy bit across successive poll reads. settled fires on a
// read whose bit matches the previous read; expired fires on the
// POLL_LIMIT-th consecutive read that differs from its predecessor.
// Assumes clear is pulsed before the first poll read of each job.
module nor_toggle_watch #(
    parameter int POLL_LIMIT = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic bit_i,
    output logic settled,
    output logic expired
);

    localparam int CW = $clog2(POLL_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

    logic          prev_q;
    logic          have_q;
    logic [CW-1:0] cnt_q;
    logic          differs;

    // A read only compares once an earlier read exists.
    assign differs = have_q && (bit_i != prev_q);
    assign settled = sample && have_q && (bit_i == prev_q);
    assign expired = sample && differs && (cnt_q == LAST);

    // Remember the last bit and count toggling reads.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_q <= 1'b0;
            have_q <= 1'b0;
            cnt_q  <= '0;
        end else if (sample) begin
            prev_q <= bit_i;
            have_q <= 1'b1;
            if (differs) cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/nor_cmd_seq.sv
// Module: nor_cmd_seq (top)
// Sequences identifier query, word program and sector erase on a parallel
// NOR flash: unlock writes, command writes, busy-bit polling with an
// iteration limit, then read-back verification. One job at a time.
// Assumes a single flash device with word addressing and DW >= 8.
module nor_cmd_seq #(
    parameter int AW           = 20,
    parameter int DW           = 16,
    parameter int ACC_CLKS     = 4,
    parameter int POLL_LIMIT   = 5000000,
    parameter int SECTOR_BYTES = 4096,
    parameter int SECT_AW      = $clog2(SECTOR_BYTES / (DW / 8)),
    parameter int LW           = SECT_AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [LW-1:0] req_len,
    output logic          busy,
    output logic          done,
    output logic [1:0]    status,
    output logic [DW-1:0] id_mfr,
    output logic [DW-1:0] id_dev,
    output logic [AW-1:0] flash_addr,
    output logic [DW-1:0] flash_dq_out,
    output logic          flash_dq_oe,
    input  logic [DW-1:0] flash_dq_in,
    output logic          flash_we_n,
    output logic          flash_oe_n
);
    import nor_seq_pkg::*;

    localparam logic [AW-1:0] A_HI  = AW'(ADDR_KEY_HI);
    localparam logic [AW-1:0] A_LO  = AW'(ADDR_KEY_LO);
    localparam logic [DW-1:0] D_K1  = DW'(CMD_KEY1);
    localparam logic [DW-1:0] D_K2  = DW'(CMD_KEY2);
    localparam logic [DW-1:0] D_PRG = DW'(CMD_PROG);
    localparam logic [DW-1:0] D_ARM = DW'(CMD_ERASE_ARM);
    localparam logic [DW-1:0] D_SEC = DW'(CMD_SECTOR);
    localparam logic [DW-1:0] D_IDE = DW'(CMD_ID_ENTER);
    localparam logic [DW-1:0] D_IDL = DW'(CMD_ID_LEAVE);

    typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_WAIT} fsm_e;

    typedef struct packed {
        kind_e         kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          last;
    } step_t;

    fsm_e          fsm;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [LW-1:0] len_q;
    logic [3:0]    step_q;
    logic [LW-1:0] vcnt_q;
    status_e       stat_q;
    logic [DW-1:0] mfr_q;
    logic [DW-1:0] dev_q;
    logic          done_q;

    logic [AW-1:0] sect_base;
    step_t         cur;
    logic          accept;
    logic          eng_ack;
    logic [DW-1:0] eng_rdata;
    logic          poll_sample;
    logic          poll_settled;
    logic          poll_expired;
    logic [DW-1:0] vfy_exp;
    logic          vfy_bad;
    logic          vfy_final;

    function automatic step_t mk(kind_e k, logic [AW-1:0] a,
                                 logic [DW-1:0] d, logic l);
        step_t s;
        s.kind = k;
        s.addr = a;
        s.data = d;
        s.last = l;
        return s;
    endfunction

    assign accept    = (fsm == F_IDLE) && req_valid && (req_op != OP_NONE);
    assign sect_base = {addr_q[AW-1:SECT_AW], {SECT_AW{1'b0}}};

    // Step table: which access each step of each job performs.
    always_comb begin
        cur = mk(K_END, '0, '0, 1'b1);
        unique case (op_q)
            OP_PROG: begin
                unique case (step_q)
                    4'd0:    cur = mk(K_WR, A_HI, D_K1, 1'b0);
                    4'd1:    cur = mk(K_WR, A_LO, D_K2, 1'b0);
                    4'd2:    cur = mk(K_WR, A_HI, D_PRG, 1'b0);
                    4'd3:    cur = mk(K_WR, addr_q, wdata_q, 1'b0);
                    4'd4:    cur = mk(K_POLL, addr_q, '0, 1'b0);
                    4'd5:    cur = mk(K_VFY, addr_q, '0, 1'b1);
                    default: cur = mk(K_END, '0, '0, 1'b1);
                endcase
            end
            OP_ERASE: begin
                unique case (step_q)
                    4'd0:    cur = mk(K_WR, A_HI, D_K1, 1'b0);
                    4'd1:    cur = mk(K_WR, A_LO, D_K2, 1'b0);
                    4'd2:    cur = mk(K_WR, A_HI, D_ARM, 1'b0);
                    4'd3:    cur = mk(K_WR, A_HI, D_K1, 1'b0);
                    4'd4:    cur = mk(K_WR, A_LO, D_K2, 1'b0);
                    4'd5:    cur = mk(K_WR, sect_base, D_SEC, 1'b0);
                    4'd6:    cur = mk(K_POLL, sect_base, '0, 1'b0);
                    4'd7:    cur = mk(K_VFY, sect_base + AW'(vcnt_q), '0, 1'b0);
                    default: cur = mk(K_END, '0, '0, 1'b1);
                endcase
            end
            OP_ID: begin
                unique case (step_q)
                    4'd0:    cur = mk(K_WR, A_HI, D_K1, 1'b0);
                    4'd1:    cur = mk(K_WR, A_LO, D_K2, 1'b0);
                    4'd2:    cur = mk(K_WR, A_HI, D_IDE, 1'b0);
                    4'd3:    cur = mk(K_ID0, '0, '0, 1'b0);
                    4'd4:    cur = mk(K_ID1, AW'(1), '0, 1'b0);
                    4'd5:    cur = mk(K_WR, A_HI, D_K1, 1'b0);
                    4'd6:    cur = mk(K_WR, A_LO, D_K2, 1'b0);
                    4'd7:    cur = mk(K_WR, A_HI, D_IDL, 1'b1);
                    default: cur = mk(K_END, '0, '0, 1'b1);
                endcase
            end
            default: cur = mk(K_END, '0, '0, 1'b1);
        endcase
    end

    // Read-back comparison for the verify phase.
    always_comb begin
        vfy_exp   = (op_q == OP_PROG) ? wdata_q : '1;
        vfy_bad   = (eng_rdata != vfy_exp);
        vfy_final = (op_q == OP_PROG) || ((vcnt_q + LW'(1)) == len_q);
    end

    assign poll_sample = (fsm == F_WAIT) && eng_ack && (cur.kind == K_POLL);

    nor_bus_engine #(
        .AW       (AW),
        .DW       (DW),
        .ACC_CLKS (ACC_CLKS)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fsm == F_ISSUE),
        .wr         (cur.kind == K_WR),
        .addr_i     (cur.addr),
        .data_i     (cur.data),
        .ack        (eng_ack),
        .rdata      (eng_rdata),
        .bus_addr   (flash_addr),
        .bus_dq_out (flash_dq_out),
        .bus_dq_oe  (flash_dq_oe),
        .bus_we_n   (flash_we_n),
        .bus_oe_n   (flash_oe_n),
        .bus_dq_in  (flash_dq_in)
    );

    nor_toggle_watch #(
        .POLL_LIMIT (POLL_LIMIT)
    ) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .sample  (poll_sample),
        .bit_i   (eng_rdata[BUSY_BIT]),
        .settled (poll_settled),
        .expired (poll_expired)
    );

    // Job sequencer: accept, issue each access, react to its result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm     <= F_IDLE;
            op_q    <= OP_NONE;
            addr_q  <= '0;
            wdata_q <= '0;
            len_q   <= '0;
            step_q  <= '0;
            vcnt_q  <= '0;
            stat_q  <= ST_OK;
            mfr_q   <= '0;
            dev_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (fsm)
                F_IDLE: begin
                    if (accept) begin
                        op_q    <= op_e'(req_op);
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        len_q   <= req_len;
                        step_q  <= '0;
                        vcnt_q  <= '0;
                        stat_q  <= ST_OK;
                        fsm     <= F_ISSUE;
                    end
                end
                F_ISSUE: fsm <= F_WAIT;
                F_WAIT: begin
                    if (eng_ack) begin
                        unique case (cur.kind)
                            K_WR, K_ID0, K_ID1: begin
                                if (cur.kind == K_ID0) mfr_q <= eng_rdata;
                                if (cur.kind == K_ID1) dev_q <= eng_rdata;
                                if (cur.last) begin
                                    fsm    <= F_IDLE;
                                    done_q <= 1'b1;
                                end else begin
                                    step_q <= step_q + 1'b1;
                                    fsm    <= F_ISSUE;
                                end
                            end
                            K_POLL: begin
                                if (poll_expired) stat_q <= ST_TIMEOUT;
                                if ((poll_settled || poll_expired) &&
                                    (op_q == OP_ERASE) && (len_q == '0)) begin
                                    fsm    <= F_IDLE;
                                    done_q <= 1'b1;
                                end else begin
                                    if (poll_settled || poll_expired)
                                        step_q <= step_q + 1'b1;
                                    fsm <= F_ISSUE;
                                end
                            end
                            K_VFY: begin
                                if (vfy_bad && (stat_q == ST_OK))
                                    stat_q <= ST_VFAIL;
                                if (vfy_bad || vfy_final) begin
                                    fsm    <= F_IDLE;
                                    done_q <= 1'b1;
                                end else begin
                                    vcnt_q <= vcnt_q + 1'b1;
                                    fsm    <= F_ISSUE;
                                end
                            end
                            default: begin
                                fsm    <= F_IDLE;
                                done_q <= 1'b1;
                            end
                        endcase
                    end
                end
                default: fsm <= F_IDLE;
            endcase
        end
    end

    assign busy   = (fsm != F_IDLE);
    assign done   = done_q;
    assign status = stat_q;
    assign id_mfr = mfr_q;
    assign id_dev = dev_q;

endmodule

// File: rtl/nor_seq_checker.sv
// Module: nor_seq_checker
// Cycle-level properties of the sequencer's bus and handshake outputs.
// Assumes it is bound into nor_cmd_seq with matching parameters.
module nor_seq_checker #(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter int ACC_CLKS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [1:0]    status,
    input logic [AW-1:0] flash_addr,
    input logic [DW-1:0] flash_dq_out,
    input logic          flash_we_n,
    input logic          flash_oe_n
);

    localparam int RW = $clog2(ACC_CLKS + 2) + 1;

    logic [RW-1:0] low_run;

    // Length of the current run of write-strobe-low clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)           low_run <= '0;
        else if (!flash_we_n) low_run <= low_run + 1'b1;
        else                  low_run <= '0;
    end

    p_strobe_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> (low_run == RW'(ACC_CLKS)));

    p_setup_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_we_n) |-> ($stable(flash_addr) && $stable(flash_dq_out)));

    p_rise_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> ($stable(flash_addr) && $stable(flash_dq_out)));

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |=> ($stable(flash_addr) && $stable(flash_dq_out)));

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_oe_n));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_status_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);

endmodule

bind nor_cmd_seq nor_seq_checker #(
    .AW       (AW),
    .DW       (DW),
    .ACC_CLKS (ACC_CLKS)
) u_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .status       (status),
    .flash_addr   (flash_addr),
    .flash_dq_out (flash_dq_out),
    .flash_we_n   (flash_we_n),
    .flash_oe_n   (flash_oe_n)
);

// File: tb/tb_nor_cmd_seq.sv
// Bench: behavioural flash model plus sweeps of program, erase and query
// jobs with expected access counts computed from the requirements.
module tb_nor_cmd_seq;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int ACC = 3;
    localparam int PL = 8;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [LW-1:0] req_len = '0;
    logic          busy, done;
    logic [1:0]    status;
    logic [DW-1:0] id_mfr, id_dev;
    logic [AW-1:0] flash_addr;
    logic [DW-1:0] flash_dq_out;
    logic          flash_dq_oe;
    logic [DW-1:0] flash_dq_in;
    logic          flash_we_n, flash_oe_n;

    always #2 clk = ~clk;

    nor_cmd_seq #(
        .AW(AW), .DW(DW), .ACC_CLKS(ACC), .POLL_LIMIT(PL), .SECTOR_BYTES(4096)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
        .busy(busy), .done(done), .status(status), .id_mfr(id_mfr),
        .id_dev(id_dev), .flash_addr(flash_addr), .flash_dq_out(flash_dq_out),
        .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in),
        .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
    );

    // ---------------- flash model ----------------
    logic [15:0] mem [0:4095];
    int          cs = 0;
    bit          id_mode = 0;
    int          busy_left = 0;
    bit          stuck = 0;
    bit          tog = 0;
    int          busy_cfg = 0;
    int          bad_seq = 0;
    int          we_cnt = 0;
    int          oe_cnt = 0;
    logic [15:0] last_erase = '0;
    bit          bad_en = 0;
    logic [11:0] bad_addr = '0;
    int          run = 0;
    int          bad_width = 0;

    always @* begin
        if (stuck || busy_left > 0) flash_dq_in = {9'd0, tog, 6'd0};
        else if (id_mode)           flash_dq_in = flash_addr[0] ? 16'h5678 : 16'h1234;
        else                        flash_dq_in = mem[flash_addr[11:0]];
    end

    always @(posedge flash_we_n) begin
        if (rst_n) begin
            we_cnt++;
            case (cs)
                0: if (flash_addr == 16'h5555 && flash_dq_out == 16'h00AA) cs = 1;
                   else bad_seq++;
                1: if (flash_addr == 16'h2AAA && flash_dq_out == 16'h0055) cs = 2;
                   else begin bad_seq++; cs = 0; end
                2: begin
                    cs = 0;
                    if (flash_addr != 16'h5555) bad_seq++;
                    else if (flash_dq_out == 16'h0090) id_mode = 1;
                    else if (flash_dq_out == 16'h00F0) id_mode = 0;
                    else if (flash_dq_out == 16'h00A0) cs = 3;
                    else if (flash_dq_out == 16'h0080) cs = 4;
                    else bad_seq++;
                end
                3: begin
                    mem[flash_addr[11:0]] = mem[flash_addr[11:0]] & flash_dq_out;
                    busy_left = busy_cfg; tog = 0; cs = 0;
                end
                4: if (flash_addr == 16'h5555 && flash_dq_out == 16'h00AA) cs = 5;
                   else begin bad_seq++; cs = 0; end
                5: if (flash_addr == 16'h2AAA && flash_dq_out == 16'h0055) cs = 6;
                   else begin bad_seq++; cs = 0; end
                default: begin
                    cs = 0;
                    if (flash_dq_out != 16'h0030) bad_seq++;
                    else begin
                        last_erase = flash_addr;
                        for (int i = 0; i < 2048; i++) mem[{flash_addr[11], 11'(i)}] = 16'hFFFF;
                        if (bad_en && bad_addr[11] == flash_addr[11]) mem[bad_addr] = 16'hFFFE;
                        busy_left = busy_cfg; tog = 0;
                    end
                end
            endcase
        end
    end

    always @(posedge flash_oe_n) begin
        if (rst_n) begin
            oe_cnt++;
            if (stuck || busy_left > 0) begin
                tog = ~tog;
                if (!stuck) busy_left--;
            end
        end
    end

    // Write strobe width measured away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !flash_we_n) run++;
        else if (run != 0) begin
            if (run != ACC) bad_width++;
            run = 0;
        end
    end

    // ---------------- checking ----------------
    int nchk = 0;
    int nbad = 0;
    int got_we, got_oe;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int pcnt(input int b, input logic [15:0] w);
        if (b == 0) return 2;
        return (int'(w[6]) == ((b - 1) % 2)) ? b + 1 : b + 2;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [15:0] a,
                          input logic [15:0] d, input int len);
        int we0, oe0;
        @(negedge clk);
        we0 = we_cnt; oe0 = oe_cnt;
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_len = LW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        got_we = we_cnt - we0;
        got_oe = oe_cnt - oe0;
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        nbad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        logic [15:0] d0;
        for (int i = 0; i < 4096; i++) mem[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 status", status, 0);
        chk("R11 strobes", {flash_we_n, flash_oe_n}, 2'b11);
        chk("R11 ids", {id_mfr, id_dev}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: identifier query
        run_op(2'd1, 16'h0000, 16'h0000, 0);
        chk("R4 mfr", id_mfr, 16'h1234);
        chk("R4 dev", id_dev, 16'h5678);
        chk("R4 writes", got_we, 6);
        chk("R4 reads", got_oe, 2);
        chk("R10 done with busy low", busy, 0);
        @(negedge clk);
        chk("R10 done one cycle", done, 0);

        // R8: len 0 erase of sector 0 skips the blank check
        busy_cfg = 0;
        run_op(2'd3, 16'h0000, 16'h0000, 0);
        chk("R8 len0 status", status, 0);
        chk("R8 len0 reads", got_oe, 2);

        // R2/R5: program sweep over busy lengths, addresses, patterns
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 4; i++) begin
                logic [15:0] a, d;
                a = 16'(16 + i * 37 + b * 200);
                d = 16'hA5C3 ^ 16'(i * 16'h1111) ^ 16'(b);
                busy_cfg = b;
                run_op(2'd2, a, d, 0);
                chk("R2 status", status, 0);
                chk("R2 writes", got_we, 4);
                chk("R2 stored", mem[a[11:0]], d);
                chk("R5 poll+verify reads", got_oe, pcnt(b, d) + 1);
            end
        end

        // R7: verify fail when a zero bit cannot be raised
        d0 = mem[16];
        busy_cfg = 1;
        run_op(2'd2, 16'd16, ~d0, 0);
        chk("R7 verify fail", status, 2);
        chk("R7 reads", got_oe, pcnt(1, 16'h0000) + 1);

        // R6/R7: timeout on program, precedence over mismatch
        stuck = 1;
        run_op(2'd2, 16'h0100, 16'h1234, 0);
        stuck = 0; busy_left = 0;
        chk("R6 program timeout", status, 1);
        chk("R6 timeout reads", got_oe, PL + 1 + 1);

        // R3/R8: erase sweep, unaligned target in sector 1
        for (int k = 0; k < 4; k++) begin
            int len;
            len = (k == 0) ? 1 : (k == 1) ? 3 : (k == 2) ? 17 : 2048;
            busy_cfg = k;
            run_op(2'd3, 16'h0923, 16'h0000, len);
            chk("R3 status", status, 0);
            chk("R3 writes", got_we, 6);
            chk("R3 sector base", last_erase, 16'h0800);
            chk("R8 reads", got_oe, pcnt(k, 16'hFFFF) + len);
        end

        // R8: a non-blank word inside and outside the checked range
        bad_en = 1; bad_addr = 12'h805; busy_cfg = 2;
        run_op(2'd3, 16'h0800, 16'h0000, 20);
        chk("R8 bad word status", status, 2);
        chk("R8 stops at bad word", got_oe, pcnt(2, 16'hFFFF) + 6);
        run_op(2'd3, 16'h0800, 16'h0000, 5);
        chk("R8 bad word beyond len", status, 0);
        chk("R8 reads short", got_oe, pcnt(2, 16'hFFFF) + 5);
        bad_en = 0;

        // R6/R8: erase timeout keeps timeout status
        stuck = 1;
        run_op(2'd3, 16'h0000, 16'h0000, 4);
        stuck = 0; busy_left = 0;
        chk("R6 erase timeout", status, 1);
        chk("R6 erase timeout reads", got_oe, PL + 1 + 1);

        // R4: after leaving identifier mode the array reads normally
        run_op(2'd1, 16'h0000, 16'h0000, 0);
        busy_cfg = 0;
        run_op(2'd2, 16'h0040, 16'h00FF, 0);
        chk("R4 array after exit", status, 0);

        // R10: request while busy is ignored
        begin
            int we0;
            int seen;
            busy_cfg = 3;
            @(negedge clk);
            req_valid = 1'b1; req_op = 2'd2; req_addr = 16'h0050; req_wdata = 16'h0F0F;
            @(negedge clk);
            req_op = 2'd1;
            @(negedge clk);
            req_valid = 1'b0;
            while (!done) @(negedge clk);
            chk("R10 first job ok", status, 0);
            we0 = we_cnt; seen = 0;
            repeat (30) begin @(negedge clk); if (busy) seen++; end
            chk("R10 busy request dropped", seen, 0);
            chk("R10 no extra writes", we_cnt - we0, 0);
            // op code 0 is ignored
            @(negedge clk);
            req_valid = 1'b1; req_op = 2'd0;
            @(negedge clk);
            req_valid = 1'b0;
            seen = 0;
            repeat (10) begin @(negedge clk); if (busy) seen++; end
            chk("R10 op0 ignored", seen, 0);
            chk("R10 op0 no writes", we_cnt - we0, 0);
        end

        chk("R1 unlock and command order", bad_seq, 0);
        chk("R9 strobe width", bad_width, 0);

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule